// File: doc/BRIEF.md
# Serial Register Slave for a Discrete Sensor Array

This block is the host-facing serial port of a 32-input discrete sensing array. A host acting as bus master talks to it over a four-wire SPI link in mode 0, with an active-low select. Every transaction begins with one command byte, and that command byte decides how many data bytes follow. Write commands fill a small configuration set:

- a control byte carrying a self-test enable and a soft-reset hold,
- a 4-bit per-bank sensing-type mask,
- two 12-bit threshold settings, each made of a 6-bit hysteresis and a 6-bit centre value, one for ground-referenced banks and one for supply-referenced banks,
- a 4-bit self-test pattern selector.

Read commands return any of these settings, or the 32-bit sensor status word. The status word can be read one 8-bit bank at a time, or as a whole.

The serial lines are brought into the system clock domain through synchronisers. The system clock must run at least four times faster than the serial clock. The output line is driven only while read data is being shifted out; at all other times it is released. The configuration registers appear as parallel outputs that feed the analog threshold logic.

Top module: `spi_regslave`

## Requirements
- R1: Data on `si` is captured on rising `sck` edges, most significant bit first. The `so` line changes only after falling `sck` edges.
- R2: A register is updated on the rising edge that completes each of its data bytes, and at no other time. The write commands and their data byte counts are: 0x02 control (1 byte), 0x04 bank type (1 byte), 0x3A ground-referenced threshold (2 bytes), 0x3C supply-referenced threshold (2 bytes), 0x1E test pattern (1 byte).
- R3: For the two-byte threshold writes, the first data byte sets the 6-bit hysteresis and the second data byte sets the 6-bit centre value.
- R4: The read commands 0x82, 0x84, 0xBA, 0xBC and 0x9E return the contents of the matching write register. Bits that are not implemented read as 0: control bits 7:2, bank-type and test-pattern bits 7:4, and threshold bits 7:6. In the control byte, bit 1 is the soft reset and bit 0 is the test enable.
- R5: Commands 0x90, 0x92, 0x94 and 0x96 each return one status byte: status[7:0], [15:8], [23:16] and [31:24] respectively. Command 0xF8 returns all four status bytes, highest byte first. The status word is captured when the command byte completes.
- R6: On a read, the MSB of the first data byte is driven after the falling `sck` edge that immediately follows the last command bit.
- R7: `so_oe` is high only during the data phase of a read, and it drops once `csn` is high. Write transactions never enable `so`.
- R8: When `csn` rises, a partially received byte is discarded and the interface returns to expecting a command byte.
- R9: Asserting `mrst_n` low clears every register to 0 at once, and also clears `so_oe`.
- R10: While control bit 1 is set, every other register and the test bit are held at 0, and writes to them are ignored. This lasts until bit 1 is written back to 0.
- R11: Unlisted commands change no register, and a read of one returns 0x00 bytes. Bytes sent beyond a command's data count are ignored on writes and read as 0x00. A second command cannot be chained inside the same `csn` window.
- R12: Data arriving on `si` while the slave is sending read data has no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the `sck` rate |
| mrst_n | input | 1 | Master reset, active low, asynchronous assert |
| sck | input | 1 | Serial clock, idles low |
| csn | input | 1 | Chip select, active low |
| si | input | 1 | Serial data from host |
| so | output | 1 | Serial data to host, high impedance when idle |
| so_oe | output | 1 | High while `so` is being driven |
| status_in | input | 32 | Sensor status word, bank 0 in bits 7:0 |
| ctrl_test | output | 1 | Self-test enable |
| ctrl_srst | output | 1 | Soft-reset hold |
| bank_type | output | 4 | Per-bank sensing type, bit n for bank n |
| gnd_hys | output | 6 | Ground-referenced hysteresis code |
| gnd_ctr | output | 6 | Ground-referenced centre code |
| sup_hys | output | 6 | Supply-referenced hysteresis code |
| sup_ctr | output | 6 | Supply-referenced centre code |
| test_pat | output | 4 | Self-test pattern selector |

## Verification
Two pairs of functions can land in the same cycle.

The first pair is the status capture and a change on `status_in`. The capture happens in the cycle the command byte completes, and the status input can change in that same window. To provoke it, the bench changes `status_in` right after sending 0xF8, then requires all four returned bytes to match the earlier word.

The second pair is the soft-reset hold and an ordinary register write. Both act on the same register in the same clock. The bench sets control bit 1 and then writes the bank-type register. It judges the outcome from the parallel output, which must stay at 0, and then from a later write, which must take effect once bit 1 has been cleared.

// File: rtl/spi_rs_pkg.sv
package spi_rs_pkg;
  localparam int BYTE_W   = 8;
  localparam int N_BANKS  = 4;
  localparam int STATUS_W = BYTE_W * N_BANKS;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CTRL, SEL_BANK, SEL_GND, SEL_SUP, SEL_TPAT, SEL_STAT1, SEL_STATALL
  } sel_e;

  typedef struct packed {
    sel_e       sel;
    logic [2:0] nbytes;
  } dec_t;

  // Command decode: direction is bit 7, target and byte count from the full code
  function automatic dec_t decode(input logic [7:0] op);
    dec_t d;
    d.sel    = SEL_NONE;
    d.nbytes = 3'd0;
    case (op)
      8'h02, 8'h82: begin d.sel = SEL_CTRL; d.nbytes = 3'd1; end
      8'h04, 8'h84: begin d.sel = SEL_BANK; d.nbytes = 3'd1; end
      8'h3A, 8'hBA: begin d.sel = SEL_GND;  d.nbytes = 3'd2; end
      8'h3C, 8'hBC: begin d.sel = SEL_SUP;  d.nbytes = 3'd2; end
      8'h1E, 8'h9E: begin d.sel = SEL_TPAT; d.nbytes = 3'd1; end
      8'h90, 8'h92, 8'h94, 8'h96: begin d.sel = SEL_STAT1; d.nbytes = 3'd1; end
      8'hF8:        begin d.sel = SEL_STATALL; d.nbytes = 3'd4; end
      default: ;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/spi_rs_sync.sv
module spi_rs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic csn_i,
  input  logic si_i,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_on,
  output logic si_o
);
  // bit order {si, csn, sck}; idle value has csn high
  localparam logic [2:0] IDLE = 3'b010;

  logic [2:0] stage_q [STAGES];
  logic       sck_prev_q;
  logic [2:0] cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= IDLE;
      sck_prev_q <= 1'b0;
    end else begin
      stage_q[0] <= {si_i, csn_i, sck_i};
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
      sck_prev_q <= stage_q[STAGES-1][0];
    end
  end

  assign cur      = stage_q[STAGES-1];
  assign cs_on    = ~cur[1];
  assign si_o     = cur[2];
  assign sck_rise = cs_on &  cur[0] & ~sck_prev_q;
  assign sck_fall = cs_on & ~cur[0] &  sck_prev_q;

  // R1: each detected edge is a single-cycle pulse
  p_rise_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sck_rise |=> !sck_rise);
  p_fall_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sck_fall |=> !sck_fall);
endmodule

// File: rtl/spi_rs_regs.sv
module spi_rs_regs
  import spi_rs_pkg::*;
#(
  parameter int THR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  sel_e             wr_sel,
  input  logic [1:0]       wr_idx,
  input  logic [THR_W-1:0] wr_data,
  output logic             ctrl_srst,
  output logic             ctrl_test,
  output logic [3:0]       bank_type,
  output logic [THR_W-1:0] gnd_hys,
  output logic [THR_W-1:0] gnd_ctr,
  output logic [THR_W-1:0] sup_hys,
  output logic [THR_W-1:0] sup_ctr,
  output logic [3:0]       test_pat
);
  logic             srst_q, srst_d, test_q, test_d;
  logic [3:0]       bank_q, bank_d, tpat_q, tpat_d;
  logic [THR_W-1:0] ghys_q, ghys_d, gctr_q, gctr_d, shys_q, shys_d, sctr_q, sctr_d;

  always_comb begin
    srst_d = srst_q; test_d = test_q; bank_d = bank_q; tpat_d = tpat_q;
    ghys_d = ghys_q; gctr_d = gctr_q; shys_d = shys_q; sctr_d = sctr_q;
    if (wr_en) begin
      case (wr_sel)
        SEL_CTRL: begin srst_d = wr_data[1]; test_d = wr_data[0]; end
        SEL_BANK: bank_d = wr_data[3:0];
        SEL_TPAT: tpat_d = wr_data[3:0];
        SEL_GND:  if (wr_idx == 2'd0) ghys_d = wr_data; else gctr_d = wr_data;
        SEL_SUP:  if (wr_idx == 2'd0) shys_d = wr_data; else sctr_d = wr_data;
        default: ;
      endcase
    end
    // soft-reset hold overrides everything except its own bit
    if (srst_d) begin
      test_d = 1'b0; bank_d = '0; tpat_d = '0;
      ghys_d = '0; gctr_d = '0; shys_d = '0; sctr_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_q <= 1'b0; test_q <= 1'b0; bank_q <= '0; tpat_q <= '0;
      ghys_q <= '0; gctr_q <= '0; shys_q <= '0; sctr_q <= '0;
    end else begin
      srst_q <= srst_d; test_q <= test_d; bank_q <= bank_d; tpat_q <= tpat_d;
      ghys_q <= ghys_d; gctr_q <= gctr_d; shys_q <= shys_d; sctr_q <= sctr_d;
    end
  end

  assign ctrl_srst = srst_q;
  assign ctrl_test = test_q;
  assign bank_type = bank_q;
  assign test_pat  = tpat_q;
  assign gnd_hys   = ghys_q;
  assign gnd_ctr   = gctr_q;
  assign sup_hys   = shys_q;
  assign sup_ctr   = sctr_q;

  // R2: without a write strobe, no register moves
  p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable({srst_q, test_q, bank_q, tpat_q, ghys_q, gctr_q, shys_q, sctr_q}));
  // R10: during the hold, every other register sits at zero
  p_srst_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |-> (!test_q && bank_q == '0 && tpat_q == '0 && ghys_q == '0
                && gctr_q == '0 && shys_q == '0 && sctr_q == '0));
endmodule

// File: rtl/spi_rs_engine.sv
module spi_rs_engine
  import spi_rs_pkg::*;
#(
  parameter int THR_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sck_rise,
  input  logic                sck_fall,
  input  logic                cs_on,
  input  logic                si,
  input  logic [STATUS_W-1:0] status_i,
  input  logic                ctrl_srst,
  input  logic                ctrl_test,
  input  logic [3:0]          bank_type,
  input  logic [THR_W-1:0]    gnd_hys,
  input  logic [THR_W-1:0]    gnd_ctr,
  input  logic [THR_W-1:0]    sup_hys,
  input  logic [THR_W-1:0]    sup_ctr,
  input  logic [3:0]          test_pat,
  output logic                wr_en,
  output sel_e                wr_sel,
  output logic [1:0]          wr_idx,
  output logic [THR_W-1:0]    wr_data,
  output logic                so_bit,
  output logic                so_oe
);
  localparam int PAD = BYTE_W - THR_W;

  logic [2:0]          bit_q, bit_d, byte_q, byte_d;
  logic [7:0]          op_q, op_d, shout_q, shout_d;
  logic [6:0]          shin_q, shin_d;
  logic                oe_q, oe_d;
  logic [STATUS_W-1:0] snap_q, snap_d;
  logic [7:0]          rx_byte, tx_byte;
  logic [1:0]          tx_idx;
  dec_t                dec;

  assign rx_byte = {shin_q, si};
  assign dec     = decode(op_q);
  assign tx_idx  = byte_q[1:0] - 2'd1;

  // read data for the byte about to be sent; zero past the command's count
  always_comb begin
    tx_byte = '0;
    if (byte_q <= dec.nbytes) begin
      case (dec.sel)
        SEL_CTRL:    tx_byte = {6'b0, ctrl_srst, ctrl_test};
        SEL_BANK:    tx_byte = {4'b0, bank_type};
        SEL_TPAT:    tx_byte = {4'b0, test_pat};
        SEL_GND:     tx_byte = (tx_idx == 2'd0) ? {{PAD{1'b0}}, gnd_hys} : {{PAD{1'b0}}, gnd_ctr};
        SEL_SUP:     tx_byte = (tx_idx == 2'd0) ? {{PAD{1'b0}}, sup_hys} : {{PAD{1'b0}}, sup_ctr};
        SEL_STAT1:   tx_byte = snap_q[int'(op_q[2:1])*BYTE_W +: BYTE_W];
        SEL_STATALL: tx_byte = snap_q[(N_BANKS-1-int'(tx_idx))*BYTE_W +: BYTE_W];
        default: ;
      endcase
    end
  end

  always_comb begin
    bit_d = bit_q; byte_d = byte_q; op_d = op_q; shin_d = shin_q;
    shout_d = shout_q; oe_d = oe_q; snap_d = snap_q;
    wr_en = 1'b0; wr_sel = dec.sel; wr_idx = tx_idx; wr_data = rx_byte[THR_W-1:0];
    if (!cs_on) begin
      bit_d = '0; byte_d = '0; op_d = '0; oe_d = 1'b0;
    end else begin
      if (sck_rise) begin
        shin_d = rx_byte[6:0];
        bit_d  = bit_q + 3'd1;
        if (bit_q == 3'd7) begin
          if (byte_q != 3'd7) byte_d = byte_q + 3'd1;
          if (byte_q == 3'd0) begin
            op_d   = rx_byte;
            snap_d = status_i;
          end else if (!op_q[7] && byte_q <= dec.nbytes) begin
            wr_en = 1'b1;
          end
        end
      end
      if (sck_fall && op_q[7] && byte_q != 3'd0) begin
        oe_d    = 1'b1;
        shout_d = (bit_q == 3'd0) ? tx_byte : {shout_q[6:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= '0; byte_q <= '0; op_q <= '0; shin_q <= '0;
      shout_q <= '0; oe_q <= 1'b0; snap_q <= '0;
    end else begin
      bit_q <= bit_d; byte_q <= byte_d; op_q <= op_d; shin_q <= shin_d;
      shout_q <= shout_d; oe_q <= oe_d; snap_q <= snap_d;
    end
  end

  assign so_bit = shout_q[7];
  assign so_oe  = oe_q;

  // R7: output enable released once select is gone
  p_oe_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_on |=> !so_oe);
  // R12: nothing is written while the slave is sending
  p_send_no_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe |-> !wr_en);
  // R1: serial output moves only on a falling edge
  p_out_on_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_fall |=> $stable(so_bit));
  // R1: bit counter wraps after the eighth rising edge
  p_bit_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_on && sck_rise && bit_q == 3'd7) |=> bit_q == 3'd0);
endmodule

// File: rtl/spi_regslave.sv
module spi_regslave
  import spi_rs_pkg::*;
#(
  parameter int THR_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                mrst_n,
  input  logic                sck,
  input  logic                csn,
  input  logic                si,
  output logic                so,
  output logic                so_oe,
  input  logic [STATUS_W-1:0] status_in,
  output logic                ctrl_test,
  output logic                ctrl_srst,
  output logic [3:0]          bank_type,
  output logic [THR_W-1:0]    gnd_hys,
  output logic [THR_W-1:0]    gnd_ctr,
  output logic [THR_W-1:0]    sup_hys,
  output logic [THR_W-1:0]    sup_ctr,
  output logic [3:0]          test_pat
);
  logic [1:0]       rst_pipe_q;
  logic             rst_n;
  logic             sck_rise, sck_fall, cs_on, si_s, so_bit;
  logic             wr_en;
  sel_e             wr_sel;
  logic [1:0]       wr_idx;
  logic [THR_W-1:0] wr_data;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge mrst_n) begin
    if (!mrst_n) rst_pipe_q <= '0;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n = rst_pipe_q[1];

  spi_rs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .csn_i(csn), .si_i(si),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_on(cs_on), .si_o(si_s)
  );

  spi_rs_engine #(.THR_W(THR_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .cs_on(cs_on), .si(si_s), .status_i(status_in),
    .ctrl_srst(ctrl_srst), .ctrl_test(ctrl_test), .bank_type(bank_type),
    .gnd_hys(gnd_hys), .gnd_ctr(gnd_ctr), .sup_hys(sup_hys), .sup_ctr(sup_ctr),
    .test_pat(test_pat), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
    .wr_data(wr_data), .so_bit(so_bit), .so_oe(so_oe)
  );

  spi_rs_regs #(.THR_W(THR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
    .wr_data(wr_data), .ctrl_srst(ctrl_srst), .ctrl_test(ctrl_test),
    .bank_type(bank_type), .gnd_hys(gnd_hys), .gnd_ctr(gnd_ctr),
    .sup_hys(sup_hys), .sup_ctr(sup_ctr), .test_pat(test_pat)
  );

  assign so = so_oe ? so_bit : 1'bz;
endmodule

// File: tb/tb_spi_regslave.sv
`timescale 1ns/1ps
module tb_spi_regslave;
  localparam int HP = 32;

  logic        clk = 1'b0;
  logic        mrst_n, sck, csn, si;
  logic [31:0] status_in;
  wire         so, so_oe;
  wire         ctrl_test, ctrl_srst;
  wire [3:0]   bank_type, test_pat;
  wire [5:0]   gnd_hys, gnd_ctr, sup_hys, sup_ctr;

  spi_regslave dut (
    .clk(clk), .mrst_n(mrst_n), .sck(sck), .csn(csn), .si(si), .so(so), .so_oe(so_oe),
    .status_in(status_in), .ctrl_test(ctrl_test), .ctrl_srst(ctrl_srst),
    .bank_type(bank_type), .gnd_hys(gnd_hys), .gnd_ctr(gnd_ctr),
    .sup_hys(sup_hys), .sup_ctr(sup_ctr), .test_pat(test_pat)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0, oe_cnt = 0;
  logic [7:0] exp_v[$];
  string      exp_tag[$];
  logic [63:0] all_regs;
  assign all_regs = {30'd0, ctrl_srst, ctrl_test, bank_type, gnd_hys, gnd_ctr,
                     sup_hys, sup_ctr, test_pat};

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_rd(input logic [7:0] v, input string tag);
    exp_v.push_back(v);
    exp_tag.push_back(tag);
  endtask

  // monitor: host-side sampling of so on rising sck, compare against scoreboard
  int         mbits = 0;
  logic [7:0] macc = '0;
  always @(posedge sck or posedge csn) begin
    if (csn) mbits = 0;
    else if (so_oe) begin
      macc = {macc[6:0], so};
      mbits++;
      if (mbits == 8) begin
        mbits = 0;
        if (exp_v.size() == 0) chk(1'b0, "R7 unexpected read byte", {56'd0, macc}, 64'd0);
        else begin
          logic [7:0] e;
          string      t;
          e = exp_v.pop_front();
          t = exp_tag.pop_front();
          chk(macc == e, t, {56'd0, macc}, {56'd0, e});
        end
      end
    end
  end

  always @(posedge clk) if (so_oe) oe_cnt <= oe_cnt + 1;

  task automatic sbits(input logic [7:0] d, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      si = d[i];
      #HP sck = 1'b1;
      #HP sck = 1'b0;
    end
  endtask

  task automatic cs_begin();
    @(negedge clk);
    csn = 1'b0;
    #HP;
  endtask

  task automatic cs_end();
    #HP csn = 1'b1;
    si = 1'b0;
    #(HP*2);
  endtask

  task automatic xfer(input int n, input logic [7:0] b0, input logic [7:0] b1 = 0,
                      input logic [7:0] b2 = 0, input logic [7:0] b3 = 0,
                      input logic [7:0] b4 = 0);
    logic [7:0] b [5];
    b = '{b0, b1, b2, b3, b4};
    cs_begin();
    for (int k = 0; k < n; k++) sbits(b[k], 8);
    cs_end();
  endtask

  initial begin
    #(4*100000);
    chk(1'b0, "watchdog expired", 64'd0, 64'd1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int oe0;
    logic [63:0] snap;
    mrst_n = 1'b0; sck = 1'b0; csn = 1'b1; si = 1'b0; status_in = '0;
    #20;
    @(negedge clk) mrst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(all_regs == 64'd0 && !so_oe, "R9 reset state", all_regs, 64'd0);

    // R2/R4 control write with junk upper bits, read back masked
    oe0 = oe_cnt;
    xfer(2, 8'h02, 8'hF1);
    chk(ctrl_test == 1'b1 && ctrl_srst == 1'b0, "R2 control write", {62'd0, ctrl_srst, ctrl_test}, 64'd1);
    chk(oe_cnt == oe0, "R7 write keeps so released", oe_cnt - oe0, 64'd0);
    expect_rd(8'h01, "R4 R6 control readback");
    xfer(2, 8'h82, 8'h00);
    chk(!so_oe, "R7 so released after csn", so_oe, 64'd0);

    xfer(2, 8'h04, 8'hFA);
    chk(bank_type == 4'hA, "R2 bank type write", bank_type, 64'hA);
    expect_rd(8'h0A, "R4 bank readback");
    xfer(2, 8'h84, 8'h00);

    // R2/R3 two-byte write, register loads per byte
    cs_begin();
    sbits(8'h3A, 8);
    sbits(8'h06, 8);
    chk(gnd_hys == 6'h06 && gnd_ctr == 6'h00, "R2 hysteresis loaded after first byte",
        {gnd_hys, gnd_ctr}, {6'h06, 6'h00});
    sbits(8'h0F, 8);
    cs_end();
    chk(gnd_ctr == 6'h0F, "R3 centre from second byte", gnd_ctr, 64'h0F);
    expect_rd(8'h06, "R3 gnd hysteresis readback");
    expect_rd(8'h0F, "R3 gnd centre readback");
    xfer(3, 8'hBA, 8'h00, 8'h00);

    xfer(3, 8'h3C, 8'hC5, 8'hD2);
    chk(sup_hys == 6'h05 && sup_ctr == 6'h12, "R3 supply threshold", {sup_hys, sup_ctr}, {6'h05, 6'h12});
    expect_rd(8'h05, "R4 supply hysteresis upper zero");
    expect_rd(8'h12, "R4 supply centre upper zero");
    xfer(3, 8'hBC, 8'h00, 8'h00);

    xfer(2, 8'h1E, 8'h34);
    chk(test_pat == 4'h4, "R2 test pattern write", test_pat, 64'h4);
    expect_rd(8'h04, "R4 test pattern readback");
    xfer(2, 8'h9E, 8'h00);

    // R5 status reads
    status_in = 32'hA1B2C3D4;
    expect_rd(8'hD4, "R5 bank0"); xfer(2, 8'h90, 8'h00);
    expect_rd(8'hC3, "R5 bank1"); xfer(2, 8'h92, 8'h00);
    expect_rd(8'hB2, "R5 bank2"); xfer(2, 8'h94, 8'h00);
    expect_rd(8'hA1, "R5 bank3"); xfer(2, 8'h96, 8'h00);
    expect_rd(8'hA1, "R5 all byte3");
    expect_rd(8'hB2, "R5 all byte2");
    expect_rd(8'hC3, "R5 all byte1");
    expect_rd(8'hD4, "R5 all byte0");
    cs_begin();
    sbits(8'hF8, 8);
    status_in = 32'h0;   // snapshot must hold old word
    for (int k = 0; k < 4; k++) sbits(8'h00, 8);
    cs_end();

    // R8 partial data byte discarded
    cs_begin(); sbits(8'h04, 8); sbits(8'hFF, 5); cs_end();
    chk(bank_type == 4'hA, "R8 partial byte dropped", bank_type, 64'hA);
    cs_begin(); sbits(8'h3C, 4); cs_end();
    xfer(2, 8'h04, 8'h03);
    chk(bank_type == 4'h3, "R8 interface restarts after partial command", bank_type, 64'h3);

    // R11 reserved codes and surplus bytes
    snap = all_regs;
    xfer(2, 8'h06, 8'h0F);
    xfer(3, 8'h00, 8'hFF, 8'hFF);
    chk(all_regs == snap, "R11 reserved write no update", all_regs, snap);
    expect_rd(8'h00, "R11 reserved read byte0");
    expect_rd(8'h00, "R11 reserved read byte1");
    xfer(3, 8'hA0, 8'h00, 8'h00);
    expect_rd(8'h03, "R11 valid read byte");
    expect_rd(8'h00, "R11 surplus read byte zero");
    xfer(3, 8'h84, 8'h00, 8'h00);
    xfer(4, 8'h04, 8'h05, 8'h02, 8'h03);
    chk(bank_type == 4'h5 && ctrl_srst == 1'b0 && ctrl_test == 1'b1, "R11 no chaining",
        {bank_type, ctrl_srst, ctrl_test}, {4'h5, 1'b0, 1'b1});

    // R12 si activity during send ignored
    snap = all_regs;
    expect_rd(8'h01, "R12 readback while si busy");
    expect_rd(8'h00, "R12 surplus while si busy");
    xfer(3, 8'h82, 8'h04, 8'hFF);
    chk(all_regs == snap, "R12 si ignored while sending", all_regs, snap);

    // R10 soft reset hold
    xfer(2, 8'h02, 8'h03);
    chk(all_regs == 64'h2_0000_0000, "R10 hold clears others", all_regs, 64'h2_0000_0000);
    xfer(2, 8'h04, 8'h0F);
    chk(bank_type == 4'h0, "R10 write blocked during hold", bank_type, 64'h0);
    expect_rd(8'h02, "R10 control reads hold bit");
    xfer(2, 8'h82, 8'h00);
    xfer(2, 8'h02, 8'h00);
    chk(!ctrl_srst && bank_type == 4'h0, "R10 release keeps reset values", bank_type, 64'h0);
    xfer(2, 8'h04, 8'h06);
    chk(bank_type == 4'h6, "R10 writes resume after release", bank_type, 64'h6);

    // R9 master reset
    xfer(3, 8'h3A, 8'h11, 8'h22);
    @(negedge clk) mrst_n = 1'b0;
    #1;
    chk(all_regs == 64'd0 && !so_oe, "R9 master reset clears", all_regs, 64'd0);
    @(negedge clk) mrst_n = 1'b1;
    repeat (5) @(negedge clk);

    chk(exp_v.size() == 0, "R6 all expected read bytes seen", exp_v.size(), 64'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule